// File: doc/BRIEF.md
# Immediate Move and Push Sequencer

This block decodes a stream of instruction bytes, one byte per accepted transfer on a valid/ready input. It handles the instructions whose second operand is a 32-bit immediate and whose work needs no arithmetic of its own. These are: loading an immediate into a register chosen by the opcode, storing an immediate to a register-or-memory operand described by a ModRM byte, and pushing an immediate onto the stack. The block assembles the four immediate bytes, lowest byte first. It then spends one execute cycle writing its eight-entry register file, driving its word-wide memory write port, or both.

The block also recognises the five short accumulator forms (and, or, xor, subtract, compare against register 0). For these it presents register 0 and the immediate to an external ALU during the execute cycle. It captures the ALU's flags and, except for compare, writes the ALU result back to register 0. Any byte it cannot decode stops the sequencer and raises a sticky error until reset.

Top module: `imm_seq`

## Requirements
- R1: After reset all eight registers read 0, the three flags are 0, `illegal` is 0, `in_ready` is 1 and no memory write occurs.
- R2: Opcodes 0xB8 to 0xBF followed by four immediate bytes write the immediate into the register numbered by opcode bits 2:0. The first byte received is bits 7:0 of the immediate.
- R3: Opcode 0xC7 with a ModRM byte whose bits 7:6 are 11 and bits 5:3 are 000 writes the immediate into the register numbered by ModRM bits 2:0, with no memory write.
- R4: Opcode 0xC7 with ModRM bits 7:6 = 00 and bits 5:3 = 000 issues exactly one memory write. The address is the register numbered by ModRM bits 2:0, the data is the immediate, and bits 7:0 of `mem_wdata` belong at the lowest byte address.
- R5: Opcode 0xC7 whose ModRM bits 5:3 are not 000, or whose bits 7:6 are 01 or 10, sets `illegal`, drops `in_ready` and performs no write.
- R6: Opcode 0x68 lowers register 4 by 4 (modulo 2^32). It writes the immediate to memory at the lowered value in the same execute cycle; 0x14 becomes 0x10.
- R7: Opcodes 0x25, 0x0D, 0x35 and 0x2D raise `alu_req` for one cycle with `alu_op` 0 (and), 1 (or), 2 (xor) or 3 (subtract), `alu_a` equal to register 0 and `alu_b` equal to the immediate. Register 0 then holds `alu_res` and the flags hold the ALU's sign, zero and overflow outputs.
- R8: Opcode 0x3D raises `alu_req` with `alu_op` 4 (compare); the flags are updated and register 0 is left unchanged.
- R9: Any opcode other than 0x0D, 0x25, 0x2D, 0x35, 0x3D, 0x68, 0xB8 to 0xBF and 0xC7 sets `illegal` on the cycle after it is accepted. `illegal` and a low `in_ready` persist until reset, and reset clears them.
- R10: `in_ready` is low for exactly one cycle, the execute cycle, after the last immediate byte of a legal instruction. Every write and ALU request of that instruction happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction byte present |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Sequencer accepts a byte this cycle |
| rd_sel | input | 3 | Register file read select |
| rd_data | output | 32 | Selected register value |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Memory byte address of the word |
| mem_wdata | output | 32 | Word to store, low byte at lowest address |
| alu_req | output | 1 | Operation request to the ALU |
| alu_op | output | 3 | ALU operation: 0 and, 1 or, 2 xor, 3 sub, 4 cmp |
| alu_a | output | 32 | First ALU operand (register 0) |
| alu_b | output | 32 | Second ALU operand (immediate) |
| alu_res | input | 32 | ALU result |
| alu_sf | input | 1 | ALU sign flag |
| alu_zf | input | 1 | ALU zero flag |
| alu_of | input | 1 | ALU overflow flag |
| flag_sf | output | 1 | Captured sign flag |
| flag_zf | output | 1 | Captured zero flag |
| flag_of | output | 1 | Captured overflow flag |
| illegal | output | 1 | Sticky decode error; sequencer halted |

## Verification
A push does two things in its single execute cycle. It updates the stack pointer and stores to memory, and the store address must be the lowered pointer, not the old one. The bench pushes with the pointer at 0x14, at 0x10 and at 0. On the execute cycle it reads register 4 through the read port and sees the old value while `mem_addr` already shows the value minus 4. One cycle later it expects register 4 to equal that address, including the wrap from 0 to 0xFFFFFFFC.

// File: rtl/imm_seq.sv
module imm_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        alu_req,
  output logic [2:0]  alu_op,
  output logic [31:0] alu_a,
  output logic [31:0] alu_b,
  input  logic [31:0] alu_res,
  input  logic        alu_sf,
  input  logic        alu_zf,
  input  logic        alu_of,
  output logic        flag_sf,
  output logic        flag_zf,
  output logic        flag_of,
  output logic        illegal
);
  localparam int SP_IDX = 4;
  localparam logic [31:0] PUSH_STEP = 32'd4;
  localparam logic [2:0] OP_CMP = 3'd4;

  typedef enum logic [2:0] {ST_OP, ST_MRM, ST_IMM, ST_EXE, ST_HALT} state_t;
  typedef enum logic [1:0] {K_MOVR, K_MOVRM, K_PUSH, K_ALU} kind_t;

  state_t      state;
  kind_t       kind, dk;
  logic [2:0]  dst, aop, dop;
  logic        to_mem, dok;
  logic [1:0]  cnt;
  logic [31:0] imm;
  logic [31:0] rf [8];

  wire take = in_valid && in_ready;
  wire exe  = state == ST_EXE;
  wire [31:0] sp_next = rf[SP_IDX] - PUSH_STEP;
  wire mrm_bad = (in_data[5:3] != 3'd0) || (in_data[7:6] == 2'b01) || (in_data[7:6] == 2'b10);

  always_comb begin
    dk  = K_ALU;
    dop = 3'd0;
    dok = 1'b1;
    if (in_data[7:3] == 5'b10111) dk = K_MOVR;
    else begin
      case (in_data)
        8'hc7:   dk = K_MOVRM;
        8'h68:   dk = K_PUSH;
        8'h25:   dop = 3'd0;
        8'h0d:   dop = 3'd1;
        8'h35:   dop = 3'd2;
        8'h2d:   dop = 3'd3;
        8'h3d:   dop = OP_CMP;
        default: dok = 1'b0;
      endcase
    end
  end

  assign in_ready  = (state == ST_OP) || (state == ST_MRM) || (state == ST_IMM);
  assign rd_data   = rf[rd_sel];
  assign mem_we    = exe && ((kind == K_PUSH) || (kind == K_MOVRM && to_mem));
  assign mem_addr  = (kind == K_PUSH) ? sp_next : rf[dst];
  assign mem_wdata = imm;
  assign alu_req   = exe && (kind == K_ALU);
  assign alu_op    = aop;
  assign alu_a     = rf[0];
  assign alu_b     = imm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OP;
      kind    <= K_MOVR;
      dst     <= 3'd0;
      aop     <= 3'd0;
      to_mem  <= 1'b0;
      cnt     <= 2'd0;
      imm     <= 32'd0;
      illegal <= 1'b0;
      flag_sf <= 1'b0;
      flag_zf <= 1'b0;
      flag_of <= 1'b0;
      for (int i = 0; i < 8; i++) rf[i] <= 32'd0;
    end else begin
      case (state)
        ST_OP: if (take) begin
          if (!dok) begin
            illegal <= 1'b1;
            state   <= ST_HALT;
          end else begin
            kind   <= dk;
            aop    <= dop;
            dst    <= in_data[2:0];
            to_mem <= 1'b0;
            cnt    <= 2'd0;
            state  <= (dk == K_MOVRM) ? ST_MRM : ST_IMM;
          end
        end
        ST_MRM: if (take) begin
          if (mrm_bad) begin
            illegal <= 1'b1;
            state   <= ST_HALT;
          end else begin
            dst    <= in_data[2:0];
            to_mem <= in_data[7:6] == 2'b00;
            state  <= ST_IMM;
          end
        end
        ST_IMM: if (take) begin
          imm <= {in_data, imm[31:8]};
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) state <= ST_EXE;
        end
        ST_EXE: begin
          case (kind)
            K_MOVR:  rf[dst] <= imm;
            K_MOVRM: if (!to_mem) rf[dst] <= imm;
            K_PUSH:  rf[SP_IDX] <= sp_next;
            K_ALU: begin
              flag_sf <= alu_sf;
              flag_zf <= alu_zf;
              flag_of <= alu_of;
              if (aop != OP_CMP) rf[0] <= alu_res;
            end
          endcase
          state <= ST_OP;
        end
        default: state <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/imm_seq_chk.sv
module imm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       mem_we,
  input logic       alu_req,
  input logic [2:0] alu_op,
  input logic       illegal
);
  // R9
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  // R9
  halt_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !in_ready);

  // R10
  exec_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !illegal) |=> in_ready);

  // R4
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R10
  write_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || alu_req) |-> !in_ready);

  // R7
  alu_op_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_req |-> (alu_op <= 3'd4));

  // R10
  no_accept_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && alu_req) |=> !alu_req);
endmodule

bind imm_seq imm_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mem_we(mem_we), .alu_req(alu_req), .alu_op(alu_op), .illegal(illegal)
);

// File: tb/imm_seq_test.sv
`timescale 1ns/1ps
module imm_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic [2:0] rd_sel = 3'd0;
  logic in_ready, mem_we, alu_req, flag_sf, flag_zf, flag_of, illegal;
  logic [31:0] rd_data, mem_addr, mem_wdata, alu_a, alu_b;
  logic [2:0] alu_op;
  logic [31:0] alu_res;
  logic alu_sf, alu_zf, alu_of;

  int nchk = 0, nfail = 0, wr_cnt = 0;
  logic [31:0] wr_addr = 0, wr_data = 0;

  always #2.5 clk = ~clk;

  imm_seq uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rd_sel(rd_sel), .rd_data(rd_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .alu_req(alu_req), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
    .alu_res(alu_res), .alu_sf(alu_sf), .alu_zf(alu_zf), .alu_of(alu_of),
    .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_of(flag_of), .illegal(illegal)
  );

  always_comb begin
    case (alu_op)
      3'd0: alu_res = alu_a & alu_b;
      3'd1: alu_res = alu_a | alu_b;
      3'd2: alu_res = alu_a ^ alu_b;
      default: alu_res = alu_a - alu_b;
    endcase
    alu_sf = alu_res[31];
    alu_zf = alu_res == 32'd0;
    alu_of = (alu_op >= 3'd3) && (alu_a[31] != alu_b[31]) && (alu_res[31] != alu_a[31]);
  end

  always @(negedge clk) if (mem_we) begin
    wr_cnt  = wr_cnt + 1;
    wr_addr = mem_addr;
    wr_data = mem_wdata;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr_cnt = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_imm(input logic [31:0] v);
    for (int k = 0; k < 4; k++) send_byte(v[8*k +: 8]);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic read_reg(input int r, output logic [31:0] v);
    rd_sel = r[2:0];
    #0.5 v = rd_data;
  endtask

  task automatic load(input int r, input logic [31:0] v);
    send_byte(8'hb8 | 8'(r));
    send_imm(v);
    settle();
  endtask

  function automatic bit legal_op(input int op);
    return (op >= 8'hb8 && op <= 8'hbf) || op == 8'hc7 || op == 8'h68 || op == 8'h25 ||
           op == 8'h0d || op == 8'h35 || op == 8'h2d || op == 8'h3d;
  endfunction

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk_eq("R1 illegal", illegal, 0);
    chk_eq("R1 in_ready", in_ready, 1);
    chk_eq("R1 flags", {flag_sf, flag_zf, flag_of}, 0);
    for (int r = 0; r < 8; r++) begin read_reg(r, v); chk_eq("R1 reg", v, 0); end
    chk_eq("R1 no write", wr_cnt, 0);

    // R2 sweep over every opcode register
    for (int r = 0; r < 8; r++) begin
      load(r, 32'h0d0c0b0a ^ (32'h11111111 * r));
      read_reg(r, v);
      chk_eq("R2 mov-by-opcode", v, 32'h0d0c0b0a ^ (32'h11111111 * r));
    end
    chk_eq("R2 no memory write", wr_cnt, 0);

    // R3 register-form store, every rm
    for (int r = 0; r < 8; r++) begin
      send_byte(8'hc7); send_byte(8'hc0 | 8'(r)); send_imm(32'ha5000000 + r);
      settle();
      read_reg(r, v);
      chk_eq("R3 reg operand", v, 32'ha5000000 + r);
    end
    chk_eq("R3 no memory write", wr_cnt, 0);

    // R4 memory-form store through every base register
    for (int r = 0; r < 8; r++) begin
      load(r, 32'h2000 + 32'h10 * r);
      send_byte(8'hc7); send_byte(8'(r)); send_imm(32'h0d0c0b0a + r);
      settle();
      chk_eq("R4 write count", wr_cnt, r + 1);
      chk_eq("R4 address", wr_addr, 32'h2000 + 32'h10 * r);
      chk_eq("R4 data", wr_data, 32'h0d0c0b0a + r);
      read_reg(r, v);
      chk_eq("R4 base unchanged", v, 32'h2000 + 32'h10 * r);
    end

    // R6 / R10 push, same-cycle pointer update and store
    load(4, 32'h14);
    wr_cnt = 0;
    for (int p = 0; p < 2; p++) begin
      send_byte(8'h68); send_imm(32'h000000af + p);
      @(negedge clk);
      chk_eq("R10 ready low in exec", in_ready, 0);
      chk_eq("R6 store strobe", mem_we, 1);
      read_reg(4, v);
      chk_eq("R6 old pointer during exec", v, 32'h14 - 4 * p);
      chk_eq("R6 address lowered", mem_addr, 32'h10 - 4 * p);
      @(negedge clk);
      chk_eq("R10 ready back", in_ready, 1);
      read_reg(4, v);
      chk_eq("R6 pointer", v, 32'h10 - 4 * p);
      chk_eq("R6 data", wr_data, 32'h000000af + p);
    end
    chk_eq("R6 count", wr_cnt, 2);
    load(4, 32'h0);
    send_byte(8'h68); send_imm(32'h12345678);
    settle();
    read_reg(4, v);
    chk_eq("R6 wrap pointer", v, 32'hfffffffc);
    chk_eq("R6 wrap address", wr_addr, 32'hfffffffc);

    // R7 accumulator forms
    load(0, 32'hff);
    send_byte(8'h25); send_imm(32'h0d0c0b0a); settle();
    read_reg(0, v); chk_eq("R7 and", v, 32'h0000000a);
    load(0, 32'hd0c0b0a0);
    send_byte(8'h0d); send_imm(32'h0d0c0b0a); settle();
    read_reg(0, v); chk_eq("R7 or", v, 32'hddccbbaa);
    load(0, 32'hddccb0a0);
    send_byte(8'h35); send_imm(32'h0d0c0b0a); settle();
    read_reg(0, v); chk_eq("R7 xor", v, 32'hd0c0bbaa);
    load(0, 32'h0d0c0baa);
    send_byte(8'h2d); send_imm(32'h0d0c0b0a);
    @(negedge clk);
    chk_eq("R7 request", alu_req, 1);
    chk_eq("R7 op code sub", alu_op, 3);
    chk_eq("R7 operand b", alu_b, 32'h0d0c0b0a);
    @(negedge clk);
    read_reg(0, v); chk_eq("R7 sub", v, 32'ha0);
    chk_eq("R7 sub flags", {flag_sf, flag_zf, flag_of}, 3'b000);
    send_byte(8'h2d); send_imm(32'ha0); settle();
    read_reg(0, v); chk_eq("R7 sub to zero", v, 0);
    chk_eq("R7 zero flag", {flag_sf, flag_zf, flag_of}, 3'b010);

    // R8 compare leaves register 0
    load(0, 32'h0d0c0b07);
    send_byte(8'h3d); send_imm(32'h0d0c0b0a); settle();
    read_reg(0, v); chk_eq("R8 reg0 kept", v, 32'h0d0c0b07);
    chk_eq("R8 less flags", {flag_sf, flag_zf, flag_of}, 3'b100);
    send_byte(8'h3d); send_imm(32'h0d0c0b07); settle();
    chk_eq("R8 equal flags", {flag_sf, flag_zf, flag_of}, 3'b010);
    load(0, 32'h80000000);
    send_byte(8'h3d); send_imm(32'h1); settle();
    chk_eq("R8 overflow flags", {flag_sf, flag_zf, flag_of}, 3'b001);
    read_reg(0, v); chk_eq("R8 reg0 kept again", v, 32'h80000000);

    // R5 bad ModRM selectors and modes
    for (int s = 1; s < 12; s++) begin
      logic [7:0] m;
      m = (s < 8) ? (8'hc3 | 8'(s << 3)) : ((s < 10) ? 8'h43 : 8'h83);
      do_reset();
      send_byte(8'hc7); send_byte(m);
      @(negedge clk);
      chk_eq("R5 illegal", illegal, 1);
      chk_eq("R5 ready low", in_ready, 0);
      repeat (6) @(negedge clk);
      chk_eq("R5 no write", wr_cnt, 0);
      read_reg(3, v); chk_eq("R5 reg untouched", v, 0);
    end

    // R9 opcode sweep
    for (int op = 0; op < 256; op++) begin
      do_reset();
      send_byte(8'(op));
      @(negedge clk);
      chk_eq("R9 decode", illegal, legal_op(op) ? 0 : 1);
    end
    do_reset();
    send_byte(8'hff);
    in_valid = 1'b1; in_data = 8'hb8;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    chk_eq("R9 stays halted", {illegal, in_ready}, 2'b10);
    do_reset();
    chk_eq("R9 reset clears", illegal, 0);
    load(2, 32'hcafef00d);
    read_reg(2, v2);
    chk_eq("R9 runs after reset", v2, 32'hcafef00d);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule